// File: doc/BRIEF.md
# Display Controller Power-On Reset Sequencer

This block brings an attached serial display controller into a known state once its supply is up. On a start request it pulses an active-low hardware reset line, if one is fitted. It then waits for the controller to boot and sends a software-reset command through a simple request/acknowledge command port. After a settling delay it reports completion. Every delay is timed by one shared down-counter, and its length is given as a parameter in clock cycles derived from the clock frequency in kHz.

In conditional mode the block first reads the controller's power-mode byte over the same port. It clears the reserved bits of that byte and compares the rest against the pattern of a panel that is already running. On a match it reports "skipped" and leaves the panel alone, so an image left on screen by an earlier boot stage does not flicker. A failed read, or any other value, leads to the full reset sequence.

The settling time after the software reset depends on whether the hardware reset pin exists. With the pin, the controller is known to be asleep and the short delay is used. Without the pin, the long worst-case delay is used. An error reported by the command port while the software reset is in progress ends the sequence in an error state.

Top module: `panel_boot_seq`

## Requirements
- R1: While reset is active and after reset releases, the panel reset output is high, the command request is low, and the busy, done, skipped and error outputs are all low.
- R2: With a reset pin fitted, a start drives the panel reset output low for exactly ceil(CLK_KHZ*PULSE_US/1000) cycles and then releases it high. The output is high whenever the block is not busy.
- R3: After the panel reset output rises, exactly CLK_KHZ*BOOT_MS cycles pass before the software-reset command request rises.
- R4: The software-reset command is opcode 0x01 with the read flag low. It is issued exactly once per reset sequence, and the request, together with a stable opcode, is held until acknowledge.
- R5: After the software-reset acknowledge without error, the block stays busy for CLK_KHZ*SETTLE_PIN_MS cycles when the pin is fitted, or CLK_KHZ*SETTLE_NOPIN_MS cycles when it is not, and then raises done.
- R6: In conditional mode the first command is a read of opcode 0x0A with the read flag high. In unconditional mode no read is issued.
- R7: Bits 7, 1 and 0 of the returned power-mode byte are ignored. When the remaining bits equal 0x1C (bits 4, 3 and 2 set), the block raises skipped and issues neither a pin pulse nor a software reset.
- R8: A power-mode read acknowledged with an error, or a masked value other than 0x1C (for example the post-reset value 0x08), leads to the full reset sequence ending in done.
- R9: An error on the software-reset acknowledge raises the error output. The error output holds until the next start, which clears it.
- R10: With no reset pin fitted (HAS_RST_PIN = 0), the panel reset output stays high at all times and the sequence starts directly with the software reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a sequence when the block is not busy |
| cond_i | input | 1 | Sampled with start: 1 selects conditional mode |
| panel_rst_n_o | output | 1 | Active-low hardware reset to the panel |
| cmd_req_o | output | 1 | Command request, held until acknowledge |
| cmd_op_o | output | 8 | Command opcode |
| cmd_rd_o | output | 1 | 1 when the command reads one byte back |
| cmd_ack_i | input | 1 | Command completed (one-cycle pulse) |
| cmd_err_i | input | 1 | Command failed; valid with acknowledge |
| cmd_rdata_i | input | 8 | Read byte; valid with acknowledge |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Reset sequence completed |
| skipped_o | output | 1 | Panel found running; no reset done |
| error_o | output | 1 | Software reset failed |

## Verification
The sequence is driven in both modes with power-mode bytes that differ only in reserved bits (0x1C, 0x9C, 0x1E), with the reset value 0x08, with a byte that has an extra defined bit set (0x3C), and with a failed read. These cases separate a correct mask from a missing or over-wide one, and show that a read error is not taken as "on". The reset-low time, the boot wait and the settle time are counted cycle by cycle. The settle time is compared between a pin-fitted instance and a pin-less instance to tell the two delay choices apart. A failed software-reset acknowledge checks that the error state holds and that a later start clears it.

// File: rtl/panel_boot_pkg.sv
package panel_boot_pkg;

   localparam logic [7:0] OP_SOFT_RESET = 8'h01;
   localparam logic [7:0] OP_READ_PWR   = 8'h0A;
   localparam logic [7:0] PWR_RSV_MASK  = 8'h83;
   localparam logic [7:0] PWR_RUNNING   = 8'h1C;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PWR_RD,
      ST_PIN_LOW,
      ST_BOOT_WAIT,
      ST_SOFT_RST,
      ST_SETTLE,
      ST_DONE,
      ST_SKIPPED,
      ST_FAIL
   } boot_state_t;

endpackage

// File: rtl/panel_boot_timer.sv
module panel_boot_timer #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   output logic          expired_o
);

   logic [CW-1:0] remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
      end else if (load_i) begin
         remain_q <= load_val_i;
      end else if (remain_q != '0) begin
         remain_q <= remain_q - 1'b1;
      end
   end

   assign expired_o = (remain_q == '0);

endmodule

// File: rtl/panel_boot_pwrchk.sv
module panel_boot_pwrchk
   import panel_boot_pkg::*;
(
   input  logic [7:0] pwr_byte_i,
   output logic       running_o
);

   logic [7:0] defined_bits;

   assign defined_bits = pwr_byte_i & ~PWR_RSV_MASK;
   assign running_o    = (defined_bits == PWR_RUNNING);

endmodule

// File: rtl/panel_boot_seq.sv
module panel_boot_seq
   import panel_boot_pkg::*;
#(
   parameter int CLK_KHZ         = 100000,
   parameter int HAS_RST_PIN     = 1,
   parameter int PULSE_US        = 20,
   parameter int BOOT_MS         = 120,
   parameter int SETTLE_PIN_MS   = 5,
   parameter int SETTLE_NOPIN_MS = 120
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       cond_i,
   output logic       panel_rst_n_o,
   output logic       cmd_req_o,
   output logic [7:0] cmd_op_o,
   output logic       cmd_rd_o,
   input  logic       cmd_ack_i,
   input  logic       cmd_err_i,
   input  logic [7:0] cmd_rdata_i,
   output logic       busy_o,
   output logic       done_o,
   output logic       skipped_o,
   output logic       error_o
);

   localparam bit PIN_FITTED  = (HAS_RST_PIN != 0);
   localparam int T_PULSE     = (CLK_KHZ * PULSE_US + 999) / 1000;
   localparam int T_BOOT      = CLK_KHZ * BOOT_MS;
   localparam int T_SETTLE    = PIN_FITTED ? CLK_KHZ * SETTLE_PIN_MS
                                           : CLK_KHZ * SETTLE_NOPIN_MS;
   localparam int T_MAX_A     = (T_PULSE > T_BOOT) ? T_PULSE : T_BOOT;
   localparam int T_MAX       = (T_MAX_A > T_SETTLE) ? T_MAX_A : T_SETTLE;
   localparam int CW          = $clog2(T_MAX + 1);

   if (CLK_KHZ < 1) begin : g_bad_clk
      $error("panel_boot_seq: CLK_KHZ must be at least 1");
   end
   if (HAS_RST_PIN != 0 && HAS_RST_PIN != 1) begin : g_bad_pin
      $error("panel_boot_seq: HAS_RST_PIN must be 0 or 1");
   end
   if (T_PULSE < 1 || T_BOOT < 1 || T_SETTLE < 1) begin : g_bad_delay
      $error("panel_boot_seq: every delay must be at least one cycle");
   end

   boot_state_t state_q, state_d;
   logic          tmr_load;
   logic [CW-1:0] tmr_val;
   logic          tmr_expired;
   logic          pwr_running;
   logic          may_start;

   panel_boot_timer #(.CW(CW)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .expired_o  (tmr_expired)
   );

   panel_boot_pwrchk u_pwrchk (
      .pwr_byte_i (cmd_rdata_i),
      .running_o  (pwr_running)
   );

   assign may_start = (state_q == ST_IDLE) || (state_q == ST_DONE) ||
                      (state_q == ST_SKIPPED) || (state_q == ST_FAIL);

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_PWR_RD: begin
            if (cmd_ack_i) begin
               if (!cmd_err_i && pwr_running) begin
                  state_d = ST_SKIPPED;
               end else if (PIN_FITTED) begin
                  state_d  = ST_PIN_LOW;
                  tmr_load = 1'b1;
                  tmr_val  = CW'(T_PULSE - 1);
               end else begin
                  state_d = ST_SOFT_RST;
               end
            end
         end
         ST_PIN_LOW: begin
            if (tmr_expired) begin
               state_d  = ST_BOOT_WAIT;
               tmr_load = 1'b1;
               tmr_val  = CW'(T_BOOT - 1);
            end
         end
         ST_BOOT_WAIT: begin
            if (tmr_expired) state_d = ST_SOFT_RST;
         end
         ST_SOFT_RST: begin
            if (cmd_ack_i) begin
               if (cmd_err_i) begin
                  state_d = ST_FAIL;
               end else begin
                  state_d  = ST_SETTLE;
                  tmr_load = 1'b1;
                  tmr_val  = CW'(T_SETTLE - 1);
               end
            end
         end
         ST_SETTLE: begin
            if (tmr_expired) state_d = ST_DONE;
         end
         default: begin
            if (may_start && start_i) begin
               if (cond_i) begin
                  state_d = ST_PWR_RD;
               end else if (PIN_FITTED) begin
                  state_d  = ST_PIN_LOW;
                  tmr_load = 1'b1;
                  tmr_val  = CW'(T_PULSE - 1);
               end else begin
                  state_d = ST_SOFT_RST;
               end
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   if (PIN_FITTED) begin : g_pin
      assign panel_rst_n_o = (state_q != ST_PIN_LOW);
   end else begin : g_nopin
      assign panel_rst_n_o = 1'b1;
   end

   assign cmd_req_o = (state_q == ST_PWR_RD) || (state_q == ST_SOFT_RST);
   assign cmd_rd_o  = (state_q == ST_PWR_RD);
   assign cmd_op_o  = (state_q == ST_PWR_RD) ? OP_READ_PWR : OP_SOFT_RESET;
   assign busy_o    = !may_start;
   assign done_o    = (state_q == ST_DONE);
   assign skipped_o = (state_q == ST_SKIPPED);
   assign error_o   = (state_q == ST_FAIL);

endmodule

// File: rtl/panel_boot_chk.sv
module panel_boot_chk #(
   parameter int HAS_RST_PIN = 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       panel_rst_n_o,
   input logic       cmd_req_o,
   input logic [7:0] cmd_op_o,
   input logic       cmd_rd_o,
   input logic       cmd_ack_i,
   input logic       busy_o,
   input logic       done_o,
   input logic       skipped_o,
   input logic       error_o
);

   AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({busy_o, done_o, skipped_o, error_o})); // R1

   AST_PIN_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> panel_rst_n_o); // R2

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req_o && !cmd_ack_i |=> cmd_req_o && $stable(cmd_op_o)); // R4

   AST_DONE_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(busy_o) && !$past(cmd_req_o)); // R5

   AST_SKIP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(skipped_o) |-> $past(cmd_rd_o && cmd_ack_i)); // R7

   AST_ERROR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      error_o && !start_i |=> error_o); // R9

   if (HAS_RST_PIN == 0) begin : g_nopin_chk
      AST_NO_PIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
         panel_rst_n_o); // R10
   end

endmodule

bind panel_boot_seq panel_boot_chk #(.HAS_RST_PIN(HAS_RST_PIN)) u_chk (.*);

// File: tb/panel_boot_seq_test.sv
module panel_boot_seq_test;

   localparam int KHZ      = 100;
   localparam int E_PULSE  = 2;
   localparam int E_BOOT   = 12000;
   localparam int E_SET_P  = 500;
   localparam int E_SET_NP = 12000;

   typedef struct packed {
      logic       cond;
      logic [7:0] pwr;
      logic       rd_err;
      logic       sr_err;
      logic [1:0] outc;   // 0 done, 1 skipped, 2 error
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 8'h00, 1'b0, 1'b0, 2'd0},
      '{1'b1, 8'h1C, 1'b0, 1'b0, 2'd1},
      '{1'b1, 8'h9C, 1'b0, 1'b0, 2'd1},
      '{1'b1, 8'h1E, 1'b0, 1'b0, 2'd1},
      '{1'b1, 8'h08, 1'b0, 1'b0, 2'd0},
      '{1'b1, 8'h3C, 1'b0, 1'b0, 2'd0},
      '{1'b1, 8'h1C, 1'b1, 1'b0, 2'd0},
      '{1'b0, 8'h00, 1'b0, 1'b1, 2'd2}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic       start_v [2];
   logic       cond_v  [2];
   logic       ack_v   [2];
   logic       err_v   [2];
   logic [7:0] rdat_v  [2];
   logic       prst_v  [2];
   logic       req_v   [2];
   logic [7:0] op_v    [2];
   logic       rd_v    [2];
   logic       busy_v  [2];
   logic       done_v  [2];
   logic       skip_v  [2];
   logic       fail_v  [2];

   int errors = 0;
   int checks = 0;

   panel_boot_seq #(.CLK_KHZ(KHZ), .HAS_RST_PIN(1)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_v[0]), .cond_i(cond_v[0]),
      .panel_rst_n_o(prst_v[0]), .cmd_req_o(req_v[0]), .cmd_op_o(op_v[0]),
      .cmd_rd_o(rd_v[0]), .cmd_ack_i(ack_v[0]), .cmd_err_i(err_v[0]),
      .cmd_rdata_i(rdat_v[0]), .busy_o(busy_v[0]), .done_o(done_v[0]),
      .skipped_o(skip_v[0]), .error_o(fail_v[0]));

   panel_boot_seq #(.CLK_KHZ(KHZ), .HAS_RST_PIN(0)) uut_nopin (
      .clk(clk), .rst_n(rst_n), .start_i(start_v[1]), .cond_i(cond_v[1]),
      .panel_rst_n_o(prst_v[1]), .cmd_req_o(req_v[1]), .cmd_op_o(op_v[1]),
      .cmd_rd_o(rd_v[1]), .cmd_ack_i(ack_v[1]), .cmd_err_i(err_v[1]),
      .cmd_rdata_i(rdat_v[1]), .busy_o(busy_v[1]), .done_o(done_v[1]),
      .skipped_o(skip_v[1]), .error_o(fail_v[1]));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // Runs one sequence on instance sel, answering commands after two cycles.
   task automatic run_seq(input int sel, input bit c, input logic [7:0] pwr,
                          input bit rderr, input bit srerr,
                          output int pulse, output int boot, output int settle,
                          output int nrd, output int nsr, output int first_op,
                          output bit bad_op);
      int lat = 0;
      int phase = 0;
      pulse = 0; boot = 0; settle = 0; nrd = 0; nsr = 0; first_op = -1; bad_op = 0;
      start_v[sel] = 1'b1;
      cond_v[sel]  = c;
      @(negedge clk);
      start_v[sel] = 1'b0;
      cond_v[sel]  = 1'b0;
      for (int cyc = 0; cyc < 40000; cyc++) begin
         ack_v[sel] = 1'b0;
         err_v[sel] = 1'b0;
         if (!busy_v[sel]) break;
         if (!prst_v[sel]) begin
            pulse++;
         end else if (req_v[sel]) begin
            lat++;
            if (lat == 2) begin
               lat = 0;
               ack_v[sel] = 1'b1;
               if (first_op < 0) first_op = int'(op_v[sel]);
               if (op_v[sel] == 8'h0A && rd_v[sel]) begin
                  nrd++;
                  err_v[sel]  = rderr;
                  rdat_v[sel] = pwr;
               end else if (op_v[sel] == 8'h01 && !rd_v[sel]) begin
                  nsr++;
                  err_v[sel] = srerr;
                  phase = 2;
               end else begin
                  bad_op = 1'b1;
               end
            end
         end else if (phase == 2) begin
            settle++;
         end else if (pulse > 0) begin
            boot++;
         end
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      int p, b, s, nr, ns, fo;
      bit bo;
      for (int i = 0; i < 2; i++) begin
         start_v[i] = 1'b0; cond_v[i] = 1'b0; ack_v[i] = 1'b0;
         err_v[i] = 1'b0; rdat_v[i] = 8'h00;
      end
      repeat (3) @(negedge clk);
      // R1: outputs during reset
      check(prst_v[0] && !req_v[0] && !busy_v[0] && !done_v[0] && !skip_v[0] && !fail_v[0],
            "R1 in reset", int'({prst_v[0], req_v[0], busy_v[0], done_v[0], skip_v[0], fail_v[0]}), 32);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(prst_v[0] && !req_v[0] && !busy_v[0] && !done_v[0] && !skip_v[0] && !fail_v[0],
            "R1 after reset", int'({prst_v[0], req_v[0], busy_v[0], done_v[0], skip_v[0], fail_v[0]}), 32);

      for (int v = 0; v < NV; v++) begin
         vec_t t = VECS[v];
         bit full = (t.outc != 2'd1);
         run_seq(0, t.cond, t.pwr, t.rd_err, t.sr_err, p, b, s, nr, ns, fo, bo);
         check(!bo, "R4 opcode/flag", int'(bo), 0);
         check(int'({fail_v[0], skip_v[0], done_v[0]}) == (1 << t.outc),
               t.outc == 2'd1 ? "R7 skip outcome" : (t.outc == 2'd2 ? "R9 error outcome" : "R8 done outcome"),
               int'({fail_v[0], skip_v[0], done_v[0]}), 1 << t.outc);
         check(nr == int'(t.cond), "R6 read count", nr, int'(t.cond));
         if (t.cond) check(fo == 8'h0A, "R6 read first", fo, 8'h0A);
         check(p == (full ? E_PULSE : 0), "R2 pulse length", p, full ? E_PULSE : 0);
         check(b == (full ? E_BOOT : 0), "R3 boot wait", b, full ? E_BOOT : 0);
         check(ns == (full ? 1 : 0), "R4 soft reset count", ns, full ? 1 : 0);
         if (t.outc == 2'd0) check(s == E_SET_P, "R5 settle with pin", s, E_SET_P);
         if (t.outc == 2'd2) begin
            repeat (20) @(negedge clk);
            check(fail_v[0] && prst_v[0], "R9 error holds", int'(fail_v[0]), 1);
            start_v[0] = 1'b1; cond_v[0] = 1'b1;
            @(negedge clk);
            start_v[0] = 1'b0; cond_v[0] = 1'b0;
            check(!fail_v[0] && busy_v[0], "R9 start clears error", int'(fail_v[0]), 0);
            // finish the read with a running panel so it ends skipped
            @(negedge clk);
            ack_v[0] = 1'b1; rdat_v[0] = 8'h1C;
            @(negedge clk);
            ack_v[0] = 1'b0;
            check(skip_v[0], "R7 skip after error", int'(skip_v[0]), 1);
         end
      end

      // no-pin instance
      run_seq(1, 1'b0, 8'h00, 1'b0, 1'b0, p, b, s, nr, ns, fo, bo);
      check(p == 0, "R10 pin never low", p, 0);
      check(b == 0 && ns == 1, "R10 direct soft reset", b, 0);
      check(s == E_SET_NP, "R5 settle without pin", s, E_SET_NP);
      check(done_v[1], "R5 no-pin done", int'(done_v[1]), 1);
      run_seq(1, 1'b1, 8'h08, 1'b0, 1'b0, p, b, s, nr, ns, fo, bo);
      check(p == 0 && nr == 1 && ns == 1 && done_v[1], "R8 no-pin reset value", p, 0);

      finish_run();
   end

endmodule